// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block is a 16-pin general-purpose I/O port that software reaches through a small word-addressed register bank. Three state registers set each pin: a direction mask, an open-drain mask and an output latch. A fourth address, the pin register, returns the pad levels after a two-stage synchronizer. A write to that address goes to the output latch.

Each register has three alias addresses next to its base address. A write to an alias clears, sets or toggles only the bits that are 1 in the written mask. Software can therefore change one pin without a read-modify-write sequence that could race other code. The bus is a simple single-cycle interface: address, write data, write strobe, and a registered read-data output. Every pin has a pad input, a pad output value and an output enable.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit is 1, every latch bit and every open-drain bit is 0, and every `pad_oe` bit is 0.
- R2: The word address is `{sel[1:0], op[1:0]}`. `sel` selects the register: 0 direction, 1 pin, 2 latch, 3 open-drain. `op` selects the action: 0 plain write, 1 clear mask, 2 set mask, 3 invert mask.
- R3: The bus is 32 bits wide. Write-data bits 31:16 have no effect, and bits 31:16 of `bus_rdata` are always 0.
- R4: A clear, set or invert write to the direction, latch or open-drain register changes exactly those bits that are 1 in the mask. It forces them to 0, forces them to 1 or toggles them. For example, mask 0x000C to the latch invert alias flips only latch bits 2 and 3.
- R5: Every write to the pin register acts on the output latch, the same way the same action on the latch address would: plain write, clear, set or invert.
- R6: A read of the direction, latch or open-drain base address returns that register's contents. The data appears on `bus_rdata` after the rising edge that samples `bus_addr`.
- R7: A read of the pin base address returns the synchronized pad levels, not the latch. A change on `pad_in` shows on `bus_rdata` (with the address held) after the third rising edge that follows it, and not earlier.
- R8: A read of any alias address (op 1, 2 or 3) returns 0.
- R9: A pin whose direction bit is 1 has `pad_oe` 0.
- R10: A pin with direction 0 and open-drain 0 has `pad_oe` 1 and `pad_out` equal to its latch bit. A register write shows on the pad outputs from the rising edge that performs it.
- R11: A pin with direction 0 and open-drain 1 has `pad_out` 0 and `pad_oe` equal to the inverse of its latch bit. The pin pulls low for latch 0 and is released for latch 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address `{sel, op}` |
| bus_wdata | input | 32 | Write data or mask |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Registered read data for the address sampled at the last edge |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Value driven onto each pad |
| pad_oe | output | 16 | Output enable for each pad |

## Verification
On every cycle, the assertions check the following:
- the upper read bits are zero;
- alias reads are zero;
- an input pin never has its driver enabled;
- an open-drain pin never drives high;
- pin-register writes and latch-invert writes land in the latch;
- pin reads return the synchronizer output.

Only the bench scenarios show the end-to-end behaviour. They sweep every register and action through several masks against an arithmetic model. They measure the exact three-edge latency from a pad change to the read data, and they show that junk in the upper write bits has no effect.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SET   = 2'd2,
    OP_FLIP  = 2'd3
  } alias_op_e;

  typedef enum logic [1:0] {
    SEL_DIR    = 2'd0,
    SEL_PIN    = 2'd1,
    SEL_LATCH  = 2'd2,
    SEL_ODRAIN = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regfield.sv
module gpio_regfield
  import gpio_pkg::*;
#(
  parameter int              W         = 16,
  parameter logic [W-1:0]    RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  alias_op_e    op,
  input  logic [W-1:0] wval,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RESET_VAL;
    end else if (wr_en) begin
      case (op)
        OP_WRITE: q <= wval;
        OP_CLEAR: q <= q & ~wval;
        OP_SET:   q <= q | wval;
        OP_FLIP:  q <= q ^ wval;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int W = 16
) (
  input  logic [W-1:0] dir_in,
  input  logic [W-1:0] odrain,
  input  logic [W-1:0] latch,
  output logic [W-1:0] out,
  output logic [W-1:0] oe
);
  for (genvar b = 0; b < W; b++) begin : g_pin
    // Open-drain pins never drive high; they release instead.
    assign out[b] = latch[b] & ~odrain[b];
    assign oe[b]  = ~dir_in[b] & ~(odrain[b] & latch[b]);
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int PIN_W = 16,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             bus_we,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0] pad_in,
  output logic [PIN_W-1:0] pad_out,
  output logic [PIN_W-1:0] pad_oe
);
  localparam int OP_BITS  = 2;
  localparam int SEL_BITS = 2;
  localparam int ADDR_W   = OP_BITS + SEL_BITS;

  reg_sel_e   sel;
  alias_op_e  op;
  logic [PIN_W-1:0] wval;
  logic [PIN_W-1:0] dir_q, latch_q, od_q, pin_sync;
  logic             dir_we, latch_we, od_we;
  logic [BUS_W-1:0] rd_next;

  assign sel  = reg_sel_e'(bus_addr[ADDR_W-1:OP_BITS]);
  assign op   = alias_op_e'(bus_addr[OP_BITS-1:0]);
  assign wval = bus_wdata[PIN_W-1:0];

  assign dir_we   = bus_we && (sel == SEL_DIR);
  assign latch_we = bus_we && ((sel == SEL_LATCH) || (sel == SEL_PIN));
  assign od_we    = bus_we && (sel == SEL_ODRAIN);

  gpio_regfield #(.W(PIN_W), .RESET_VAL({PIN_W{1'b1}})) u_dir (
    .clk(clk), .rst(rst), .wr_en(dir_we), .op(op), .wval(wval), .q(dir_q)
  );
  gpio_regfield #(.W(PIN_W), .RESET_VAL('0)) u_latch (
    .clk(clk), .rst(rst), .wr_en(latch_we), .op(op), .wval(wval), .q(latch_q)
  );
  gpio_regfield #(.W(PIN_W), .RESET_VAL('0)) u_odrain (
    .clk(clk), .rst(rst), .wr_en(od_we), .op(op), .wval(wval), .q(od_q)
  );

  gpio_sync #(.W(PIN_W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_pad_drive #(.W(PIN_W)) u_drive (
    .dir_in(dir_q), .odrain(od_q), .latch(latch_q), .out(pad_out), .oe(pad_oe)
  );

  always_comb begin
    rd_next = '0;
    if (op == OP_WRITE) begin
      case (sel)
        SEL_DIR:    rd_next[PIN_W-1:0] = dir_q;
        SEL_PIN:    rd_next[PIN_W-1:0] = pin_sync;
        SEL_LATCH:  rd_next[PIN_W-1:0] = latch_q;
        SEL_ODRAIN: rd_next[PIN_W-1:0] = od_q;
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int PIN_W = 16,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic             bus_we,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [PIN_W-1:0] pad_out,
  input logic [PIN_W-1:0] pad_oe,
  input logic [PIN_W-1:0] dir_q,
  input logic [PIN_W-1:0] latch_q,
  input logic [PIN_W-1:0] od_q,
  input logic [PIN_W-1:0] pin_sync
);
  assert_rdata_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:PIN_W] == '0);

  assert_alias_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[1:0] != 2'd0) |=> (bus_rdata == '0));

  assert_input_released_R9: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & dir_q) == '0);

  assert_odrain_no_high_R11: assert property (@(posedge clk) disable iff (rst)
    ((pad_out & od_q) == '0) && ((pad_oe & od_q & latch_q) == '0));

  assert_pin_write_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'h4) |=> (latch_q == $past(bus_wdata[PIN_W-1:0])));

  assert_latch_flip_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'hB) |=> (latch_q == $past(latch_q ^ bus_wdata[PIN_W-1:0])));

  assert_pin_read_sync_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 4'h4) |=> (bus_rdata[PIN_W-1:0] == $past(pin_sync)));
endmodule

bind gpio_bank gpio_bank_chk #(.PIN_W(PIN_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .dir_q(dir_q), .latch_q(latch_q), .od_q(od_q), .pin_sync(pin_sync)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;

  int n_run = 0;
  int n_fail = 0;

  logic [15:0] m_dir, m_lat, m_od;

  gpio_bank dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [15:0] apply(input logic [1:0] op, input logic [15:0] cur,
                                        input logic [15:0] m);
    case (op)
      2'd0: return m;
      2'd1: return cur & ~m;
      2'd2: return cur | m;
      default: return cur ^ m;
    endcase
  endfunction

  task automatic check_pads(input string tag);
    logic [15:0] exp_oe, exp_out;
    exp_out = m_lat & ~m_od;
    exp_oe  = ~m_dir & ~(m_od & m_lat);
    check({tag, " R10 R11 pad_out"}, {16'h0, pad_out}, {16'h0, exp_out});
    check({tag, " R9 R10 R11 pad_oe"}, {16'h0, pad_oe}, {16'h0, exp_oe});
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] masks [4];
    masks[0] = 32'h0000_000C;
    masks[1] = 32'hFFFF_FFFF;
    masks[2] = 32'h5A5A_A5A5;
    masks[3] = 32'h0001_8001;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_dir = 16'hFFFF; m_lat = '0; m_od = '0;

    // R1: reset state
    check("R1 pad_oe after reset", {16'h0, pad_oe}, 32'h0);
    bus_read(4'h0, rd); check("R1 dir reset", rd, 32'h0000_FFFF);
    bus_read(4'h8, rd); check("R1 latch reset", rd, 32'h0);
    bus_read(4'hC, rd); check("R1 odrain reset", rd, 32'h0);

    // R2 R4 R5 R6 R8: sweep every register and action
    for (int sel = 0; sel < 4; sel++) begin
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < 4; k++) begin
          logic [3:0] a;
          a = {sel[1:0], op[1:0]};
          bus_write(a, masks[k]);
          case (sel)
            0: m_dir = apply(op[1:0], m_dir, masks[k][15:0]);
            3: m_od  = apply(op[1:0], m_od,  masks[k][15:0]);
            default: m_lat = apply(op[1:0], m_lat, masks[k][15:0]);
          endcase
          check_pads("sweep");
          bus_read(4'h0, rd); check("R2 R4 R6 dir readback", rd, {16'h0, m_dir});
          bus_read(4'h8, rd); check("R2 R4 R5 R6 latch readback", rd, {16'h0, m_lat});
          bus_read(4'hC, rd); check("R2 R4 R6 odrain readback", rd, {16'h0, m_od});
          if (op != 0) begin
            bus_read(a, rd); check("R8 alias read zero", rd, 32'h0);
          end
        end
      end
    end

    // R4: the 0x000C invert example on a known latch
    bus_write(4'h8, 32'h0000_0005); m_lat = 16'h0005;
    bus_write(4'hB, 32'h0000_000C); m_lat = 16'h0009;
    bus_read(4'h8, rd); check("R4 invert 0x000C", rd, 32'h0000_0009);

    // R3: upper write bits ignored
    bus_write(4'h8, 32'hFFFF_0000); m_lat = 16'h0000;
    bus_read(4'h8, rd); check("R3 upper bits ignored", rd, 32'h0);
    bus_write(4'h0, 32'hABCD_0000); m_dir = 16'h0000;
    bus_read(4'h0, rd); check("R3 dir upper ignored", rd, 32'h0);
    check_pads("R3");

    // R11 / R10: mixed open-drain and push-pull pins
    bus_write(4'hC, 32'h0000_00FF); m_od = 16'h00FF;
    bus_write(4'h8, 32'h0000_0F0F); m_lat = 16'h0F0F;
    check_pads("mixed");

    // R7: pin reads return synchronized pads with three-edge latency
    bus_write(4'h8, 32'h0000_3C3C); m_lat = 16'h3C3C;
    @(negedge clk); bus_addr = 4'h4;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 20; p++) begin
      logic [15:0] oldv, newv;
      oldv = pad_in;
      newv = (p < 16) ? (16'h1 << p) : (p == 16) ? 16'hFFFF : (p == 17) ? 16'hA5A5 :
             (p == 18) ? 16'h3C3C : 16'h0000;
      pad_in = newv;
      @(negedge clk); check("R7 not yet after 1 edge", rd_pin(), {16'h0, oldv});
      @(negedge clk); check("R7 not yet after 2 edges", rd_pin(), {16'h0, oldv});
      @(negedge clk); check("R7 visible after 3 edges", rd_pin(), {16'h0, newv});
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [31:0] rd_pin();
    return bus_rdata;
  endfunction
endmodule